// File: doc/BRIEF.md
# Amplifier Fault Interrupt and Safe-Mode Controller

This block gathers the digital fault indications of a Class D power stage and turns them into a sticky status register, a mask register and one active-low interrupt line. The fault sources are an output short detector, an over-temperature warning, an over-temperature error, a loss of the master clock and a mismatch between the internal master-clock-to-frame-clock ratio and its configured value. Software reaches the block through a simple strobed register port. Reads carry a burst flag, and the block refuses burst reads that land in its fault bank.

An output short or an over-temperature error drops the amplifier into a protective safe mode that stops switching. Each of these two faults has its own release bit in the control register. Safe mode ends only after the fault has gone away and software has pulsed the matching release bit. A clock watchdog runs on the block clock, which acts as the reference. It counts synchronised master clock rising edges over a fixed window. When the count is too low, it raises the clock error and latches an output clamp that only a reset removes. The reference clock must run at more than twice the master clock rate it supervises.

Top module: `amp_fault_ctrl`

## Requirements
- R1: The mask register at address 0x14 resets to 0xFF. Bits 4:0 are writable and map one-to-one onto status bits 4:0. A 1 masks the source and a 0 unmasks it. Bits 7:5 always read 1.
- R2: The read-only status register sits at address 0x15. Bit 0 is over-temperature error, bit 1 is over-temperature warning, bit 2 is output short, bit 3 is master clock error and bit 4 is ratio error. Bits 7:5 read 0. A bit is sticky: it is set in the cycle after its source is seen. A single read of 0x15 clears it unless the source is still present at that edge.
- R3: irq_no is low exactly when some status bit is 1 and its mask bit is 0. Otherwise it is high.
- R4: In the cycle after an over-temperature error, safe_mode_o goes high. It also goes high in the cycle after a short, provided the amplifier is not powered down. While safe mode is active, amp_stop_o is high.
- R5: Safe mode leaves in the cycle after a 1 to 0 transition of the release bit that belongs to the latched fault, provided that fault input is low at that moment. Control bit 1 releases a short and control bit 2 releases an over-temperature error. The other fault's release bit has no effect.
- R6: While the power-down bit is 1 or safe mode is active, the short input is ignored. It neither sets status bit 2 nor enters safe mode.
- R7: The control register sits at address 0x10. Bit 0 is amplifier power-down and resets to 1. Bits 1 and 2 are the release bits and reset to 0. The register reads back its value, and amp_pdn_o follows bit 0.
- R8: The watchdog counts synchronised master clock rising edges over windows of 64 block clock cycles. A window with fewer than 8 edges raises status bit 3 and latches out_clamp_o, which also forces amp_stop_o high. Both stay latched until rst_ni. A window with exactly 8 edges is not an error.
- R9: A read with the burst flag set to any address from 0x14 to 0x17 returns 0x00 and does not clear status.
- R10: The ratio error input sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the watchdog reference |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_i | input | 1 | Master clock under supervision |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_burst_i | input | 1 | Read is part of an auto-increment burst |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid while reg_re_i is high |
| short_det_i | input | 1 | Output short detected |
| otw_i | input | 1 | Over-temperature warning |
| ote_i | input | 1 | Over-temperature error |
| ratio_err_i | input | 1 | Clock ratio mismatch |
| irq_no | output | 1 | Interrupt request, active low |
| safe_mode_o | output | 1 | Protective safe mode active |
| amp_stop_o | output | 1 | Amplifier must stop switching |
| out_clamp_o | output | 1 | Outputs clamped to ground after clock loss |
| amp_pdn_o | output | 1 | Amplifier power-down |

## Verification
The bench tries to release a latched short while the short is still present, and tries to release each fault with the other fault's bit. A design that checks the wrong bit or ignores the fault level would exit safe mode early. It holds a short during power-down and during safe mode. A detector that is not gated would set the short status again right after the read that cleared it. It drives the master clock at exactly the threshold of 8 edges per window, then below it, then back to a healthy rate. An off-by-one comparison would clamp a good clock, and a clamp that is not latched would let go once the clock recovers. Burst reads of a pending status must return zero and leave the bit set; a design without the guard would hand out and lose the bit.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned NSRC = 5;
  localparam int unsigned NFLT = 2;

  localparam logic [7:0] A_CTRL    = 8'h10;
  localparam logic [7:0] A_MASK    = 8'h14;
  localparam logic [7:0] A_STAT    = 8'h15;
  localparam logic [7:0] A_BANK_LO = 8'h14;
  localparam logic [7:0] A_BANK_HI = 8'h17;

  // status bit positions
  typedef enum int unsigned {
    S_OTE   = 0,
    S_OTW   = 1,
    S_SHORT = 2,
    S_MCLK  = 3,
    S_RATIO = 4
  } src_e;

  localparam int unsigned F_SHORT = 0;
  localparam int unsigned F_OTE   = 1;

  typedef struct packed {
    logic ote_rls;
    logic short_rls;
    logic pdn;
  } ctrl_t;
endpackage

// File: rtl/afc_mclk_wdog.sv
module afc_mclk_wdog #(
  parameter int unsigned WIN_CYC   = 64,
  parameter int unsigned MIN_EDGES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_i,
  output logic mclk_low_o,
  output logic mclk_dead_o
);
  localparam int unsigned CW = $clog2(WIN_CYC);
  localparam int unsigned EW = $clog2(WIN_CYC + 1);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic [CW-1:0] win_q;
  logic [EW-1:0] cnt_q;
  logic [EW-1:0] cnt_nxt;
  logic          low_q;
  logic          dead_q;
  logic          rise;
  logic          win_end;

  assign rise    = sync_q[1] & ~prev_q;
  assign win_end = (win_q == CW'(WIN_CYC - 1));
  assign cnt_nxt = cnt_q + EW'(rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      win_q  <= '0;
      cnt_q  <= '0;
      low_q  <= 1'b0;
      dead_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], mclk_i};
      prev_q <= sync_q[1];
      dead_q <= dead_q | low_q;
      if (win_end) begin
        win_q <= '0;
        cnt_q <= '0;
        low_q <= (cnt_nxt < EW'(MIN_EDGES));
      end else begin
        win_q <= win_q + CW'(1);
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign mclk_low_o  = low_q;
  assign mclk_dead_o = dead_q;
endmodule

// File: rtl/afc_safe_latch.sv
module afc_safe_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic fault_i,
  input  logic rls_i,
  output logic safe_o
);
  logic rls_q;
  logic safe_q;
  logic rls_fall;

  assign rls_fall = rls_q & ~rls_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rls_q  <= 1'b0;
      safe_q <= 1'b0;
    end else begin
      rls_q <= rls_i;
      if (set_i)                     safe_q <= 1'b1;
      else if (rls_fall && !fault_i) safe_q <= 1'b0;
    end
  end

  assign safe_o = safe_q;
endmodule

// File: rtl/afc_regs.sv
module afc_regs
  import afc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            re_i,
  input  logic            burst_i,
  input  logic [7:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSRC-1:0] src_i,
  output ctrl_t           ctrl_o,
  output logic            irq_no
);
  localparam int unsigned CTW = $bits(ctrl_t);

  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] stat_q;
  ctrl_t           ctrl_q;
  logic            in_bank;
  logic            rd_ok;
  logic            stat_clr;
  logic            unused_wdata;

  assign in_bank      = (addr_i >= A_BANK_LO) && (addr_i <= A_BANK_HI);
  assign rd_ok        = re_i && !(burst_i && in_bank);
  assign stat_clr     = rd_ok && (addr_i == A_STAT);
  assign unused_wdata = ^wdata_i[DW-1:NSRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      stat_q <= '0;
      ctrl_q <= '{ote_rls: 1'b0, short_rls: 1'b0, pdn: 1'b1};
    end else begin
      if (we_i && addr_i == A_MASK) mask_q <= wdata_i[NSRC-1:0];
      if (we_i && addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTW-1:0]);
      stat_q <= src_i | (stat_clr ? '0 : stat_q);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      unique case (addr_i)
        A_CTRL:  rdata_o = DW'(ctrl_q);
        A_MASK:  rdata_o = {{(DW-NSRC){1'b1}}, mask_q};
        A_STAT:  rdata_o = DW'(stat_q);
        default: rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign irq_no = ~|(stat_q & ~mask_q);
endmodule

// File: rtl/amp_fault_ctrl.sv
module amp_fault_ctrl
  import afc_pkg::*;
#(
  parameter int unsigned WIN_CYC   = 64,
  parameter int unsigned MIN_EDGES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mclk_i,
  input  logic       reg_we_i,
  input  logic       reg_re_i,
  input  logic       reg_burst_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       short_det_i,
  input  logic       otw_i,
  input  logic       ote_i,
  input  logic       ratio_err_i,
  output logic       irq_no,
  output logic       safe_mode_o,
  output logic       amp_stop_o,
  output logic       out_clamp_o,
  output logic       amp_pdn_o
);
  ctrl_t           ctrl;
  logic            short_rls;
  logic            ote_rls;
  logic            mclk_low;
  logic            mclk_dead;
  logic            safe_any;
  logic            short_eff;
  logic [NSRC-1:0] src;
  logic [NFLT-1:0] flt_set;
  logic [NFLT-1:0] flt_raw;
  logic [NFLT-1:0] flt_rls;
  logic [NFLT-1:0] flt_safe;

  assign short_rls = ctrl.short_rls;
  assign ote_rls   = ctrl.ote_rls;
  // detector is blind while powered down or already protected
  assign short_eff = short_det_i & ~ctrl.pdn & ~safe_any;

  always_comb begin
    src          = '0;
    src[S_OTE]   = ote_i;
    src[S_OTW]   = otw_i;
    src[S_SHORT] = short_eff;
    src[S_MCLK]  = mclk_low;
    src[S_RATIO] = ratio_err_i;
  end

  always_comb begin
    flt_set          = '0;
    flt_raw          = '0;
    flt_rls          = '0;
    flt_set[F_SHORT] = short_eff;
    flt_raw[F_SHORT] = short_det_i;
    flt_rls[F_SHORT] = short_rls;
    flt_set[F_OTE]   = ote_i;
    flt_raw[F_OTE]   = ote_i;
    flt_rls[F_OTE]   = ote_rls;
  end

  afc_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .re_i    (reg_re_i),
    .burst_i (reg_burst_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .src_i   (src),
    .ctrl_o  (ctrl),
    .irq_no  (irq_no)
  );

  afc_mclk_wdog #(
    .WIN_CYC   (WIN_CYC),
    .MIN_EDGES (MIN_EDGES)
  ) i_wdog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mclk_i      (mclk_i),
    .mclk_low_o  (mclk_low),
    .mclk_dead_o (mclk_dead)
  );

  for (genvar g = 0; g < NFLT; g++) begin : g_safe
    afc_safe_latch i_latch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (flt_set[g]),
      .fault_i (flt_raw[g]),
      .rls_i   (flt_rls[g]),
      .safe_o  (flt_safe[g])
    );
  end

  assign safe_any    = |flt_safe;
  assign safe_mode_o = safe_any;
  assign out_clamp_o = mclk_dead;
  assign amp_stop_o  = safe_any | mclk_dead | ctrl.pdn;
  assign amp_pdn_o   = ctrl.pdn;
endmodule

// File: rtl/amp_fault_ctrl_chk.sv
module amp_fault_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic       reg_re_i,
  input logic       reg_burst_i,
  input logic [7:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       short_det_i,
  input logic       ote_i,
  input logic       irq_no,
  input logic       safe_mode_o,
  input logic       amp_stop_o,
  input logic       out_clamp_o,
  input logic       amp_pdn_o,
  input logic       short_rls,
  input logic       ote_rls
);
  p_all_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 8'h14 && reg_wdata_i[4:0] == 5'h1f) |=> irq_no);

  p_short_enter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_det_i && !amp_pdn_o && !safe_mode_o) |=> safe_mode_o);

  p_ote_enter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ote_i |=> safe_mode_o);

  p_safe_stops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    safe_mode_o |-> amp_stop_o);

  p_exit_after_rls_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(safe_mode_o) |->
      (($past(short_rls, 2) && !$past(short_rls)) || ($past(ote_rls, 2) && !$past(ote_rls))));

  p_exit_ote_gone_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(safe_mode_o) |-> !$past(ote_i));

  p_clamp_latched_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_clamp_o |=> out_clamp_o);

  p_clamp_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_clamp_o |-> amp_stop_o);

  p_burst_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_burst_i && reg_addr_i >= 8'h14 && reg_addr_i <= 8'h17) |-> reg_rdata_o == 8'h00);
endmodule

bind amp_fault_ctrl amp_fault_ctrl_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_burst_i (reg_burst_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .short_det_i (short_det_i),
  .ote_i       (ote_i),
  .irq_no      (irq_no),
  .safe_mode_o (safe_mode_o),
  .amp_stop_o  (amp_stop_o),
  .out_clamp_o (out_clamp_o),
  .amp_pdn_o   (amp_pdn_o),
  .short_rls   (short_rls),
  .ote_rls     (ote_rls)
);

// File: tb/test_amp_fault_ctrl.sv
module test_amp_fault_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 64;
  localparam int MINE = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic mclk = 1'b0;
  logic we = 1'b0, re = 1'b0, burst = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic short_det = 1'b0, otw = 1'b0, ote = 1'b0, ratio = 1'b0;
  logic irq_n, safe, stop, clamp, pdn;

  int n_chk = 0;
  int n_err = 0;
  int mdiv = 2;
  int mcnt = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  amp_fault_ctrl i_amp_fault_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mclk_i(mclk),
    .reg_we_i(we), .reg_re_i(re), .reg_burst_i(burst),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .short_det_i(short_det), .otw_i(otw), .ote_i(ote), .ratio_err_i(ratio),
    .irq_no(irq_n), .safe_mode_o(safe), .amp_stop_o(stop),
    .out_clamp_o(clamp), .amp_pdn_o(pdn)
  );

  // behavioural reference model
  logic [4:0] m_mask, m_stat;
  logic [2:0] m_ctrl;
  logic m_prv_s, m_prv_o, m_safe_s, m_safe_o, m_low, m_dead;
  logic mh[$];
  int m_win, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 5'h1f; m_stat = '0; m_ctrl = 3'b001;
      m_prv_s = 0; m_prv_o = 0; m_safe_s = 0; m_safe_o = 0;
      m_low = 0; m_dead = 0; m_win = 0; m_cnt = 0;
      mh = {1'b0, 1'b0, 1'b0};
    end else begin
      logic in_safe, s_eff, rd_ok, edge_seen, fs, fo, n_low;
      logic [4:0] src;
      in_safe = m_safe_s | m_safe_o;
      s_eff = short_det && !m_ctrl[0] && !in_safe;
      rd_ok = re && !(burst && addr >= 8'h14 && addr <= 8'h17);
      src = {ratio, m_low, s_eff, otw, ote};
      fs = m_prv_s && !m_ctrl[1];
      fo = m_prv_o && !m_ctrl[2];
      mh.push_front(mclk);
      edge_seen = mh[2] && !mh[3];
      void'(mh.pop_back());
      n_low = m_low;
      if (m_win == WIN-1) begin
        n_low = (m_cnt + int'(edge_seen)) < MINE;
        m_cnt = 0; m_win = 0;
      end else begin
        m_cnt += int'(edge_seen); m_win++;
      end
      m_dead = m_dead | m_low;
      m_low = n_low;
      m_stat = src | ((rd_ok && addr == 8'h15) ? 5'h0 : m_stat);
      if (s_eff) m_safe_s = 1; else if (fs && !short_det) m_safe_s = 0;
      if (ote) m_safe_o = 1; else if (fo && !ote) m_safe_o = 0;
      m_prv_s = m_ctrl[1]; m_prv_o = m_ctrl[2];
      if (we && addr == 8'h14) m_mask = wdata[4:0];
      if (we && addr == 8'h10) m_ctrl = wdata[2:0];
    end
  end

  function automatic logic [7:0] m_rdata();
    if (!re || (burst && addr >= 8'h14 && addr <= 8'h17)) return 8'h00;
    case (addr)
      8'h10: return {5'b0, m_ctrl};
      8'h14: return {3'b111, m_mask};
      8'h15: return {3'b000, m_stat};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(cur_req, {3'b0, irq_n, safe, stop, clamp, pdn},
          {3'b0, ~|(m_stat & ~m_mask), m_safe_s | m_safe_o,
           m_safe_s | m_safe_o | m_dead | m_ctrl[0], m_dead, m_ctrl[0]}, "outputs");
      chk(cur_req, rdata, m_rdata(), "rdata");
      if (mdiv != 0) begin
        mcnt++;
        if (mcnt >= mdiv) begin mcnt = 0; mclk = ~mclk; end
      end
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    we = 1; addr = a; wdata = d;
    step(1);
    we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic b, logic [7:0] exp, string req);
    re = 1; burst = b; addr = a;
    #1;
    chk(req, rdata, exp, $sformatf("read %h burst %0b", a, b));
    step(1);
    re = 0; burst = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    // R1 R7 reset state
    cur_req = "R1";
    rd(8'h14, 0, 8'hff, "R1");
    chk("R3", {7'b0, irq_n}, 8'h01, "irq after reset");
    cur_req = "R7";
    rd(8'h10, 0, 8'h01, "R7");
    chk("R7", {7'b0, pdn}, 8'h01, "pdn after reset");
    rd(8'h15, 0, 8'h00, "R2");

    // R10 R3 R2 ratio error, sticky then clear-on-read
    cur_req = "R10";
    wr(8'h14, 8'h00);
    rd(8'h14, 0, 8'he0, "R1");
    ratio = 1; step(1); ratio = 0; step(1);
    chk("R3", {7'b0, irq_n}, 8'h00, "irq unmasked ratio");
    rd(8'h15, 0, 8'h10, "R10");
    rd(8'h15, 0, 8'h00, "R2");
    chk("R3", {7'b0, irq_n}, 8'h01, "irq after clear");
    ratio = 1; step(2);
    rd(8'h15, 0, 8'h10, "R2");
    rd(8'h15, 0, 8'h10, "R2");
    ratio = 0;

    // R3 masking
    cur_req = "R3";
    wr(8'h14, 8'h1f); step(1);
    chk("R3", {7'b0, irq_n}, 8'h01, "irq all masked");
    wr(8'h14, 8'h0f); step(1);
    chk("R3", {7'b0, irq_n}, 8'h00, "irq ratio unmasked");
    rd(8'h15, 0, 8'h10, "R3");
    wr(8'h14, 8'h00);

    // R6 short ignored while powered down
    cur_req = "R6";
    short_det = 1; step(3);
    chk("R6", {7'b0, safe}, 8'h00, "safe while pdn");
    rd(8'h15, 0, 8'h00, "R6");
    // R4 short enters safe mode
    cur_req = "R4";
    wr(8'h10, 8'h00); step(1);
    chk("R4", {6'b0, safe, stop}, 8'h03, "safe+stop after short");
    rd(8'h15, 0, 8'h04, "R4");
    cur_req = "R6";
    rd(8'h15, 0, 8'h00, "R6");
    // R5 release while short present
    cur_req = "R5";
    wr(8'h10, 8'h02); wr(8'h10, 8'h00); step(2);
    chk("R5", {7'b0, safe}, 8'h01, "release with short present");
    short_det = 0; step(1);
    wr(8'h10, 8'h04); wr(8'h10, 8'h00); step(2);
    chk("R5", {7'b0, safe}, 8'h01, "wrong release bit");
    wr(8'h10, 8'h02); wr(8'h10, 8'h00); step(2);
    chk("R5", {6'b0, safe, stop}, 8'h00, "short released");
    rd(8'h10, 0, 8'h00, "R7");

    // R4 R5 over-temperature error
    cur_req = "R4";
    ote = 1; step(1);
    chk("R4", {7'b0, safe}, 8'h01, "safe after ote");
    wr(8'h10, 8'h04); wr(8'h10, 8'h00); step(2);
    chk("R5", {7'b0, safe}, 8'h01, "release with ote present");
    ote = 0; step(1);
    rd(8'h15, 0, 8'h01, "R2");
    cur_req = "R5";
    wr(8'h10, 8'h02); wr(8'h10, 8'h00); step(2);
    chk("R5", {7'b0, safe}, 8'h01, "short bit on ote fault");
    wr(8'h10, 8'h04); wr(8'h10, 8'h00); step(2);
    chk("R5", {7'b0, safe}, 8'h00, "ote released");

    // R2 warning does not protect
    cur_req = "R2";
    otw = 1; step(1); otw = 0; step(1);
    chk("R2", {7'b0, safe}, 8'h00, "no safe on warning");
    rd(8'h15, 0, 8'h02, "R2");

    // R9 burst guard
    cur_req = "R9";
    ratio = 1; step(1); ratio = 0; step(1);
    rd(8'h15, 1, 8'h00, "R9");
    rd(8'h14, 1, 8'h00, "R9");
    chk("R9", {7'b0, irq_n}, 8'h00, "irq kept after burst");
    rd(8'h15, 0, 8'h10, "R9");

    // R8 clock watchdog
    cur_req = "R8";
    mdiv = 4; step(300);
    chk("R8", {7'b0, clamp}, 8'h00, "threshold clock");
    rd(8'h15, 0, 8'h00, "R8");
    mdiv = 8; step(300);
    chk("R8", {6'b0, clamp, stop}, 8'h03, "slow clock clamp");
    rd(8'h15, 0, 8'h08, "R8");
    mdiv = 2; step(300);
    chk("R8", {7'b0, clamp}, 8'h01, "clamp held after recovery");
    do_reset();
    chk("R8", {7'b0, clamp}, 8'h00, "clamp cleared by reset");
    step(200);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule